// File: doc/BRIEF.md
# Windowed Trigger Watchdog with Give-Up Counter

This block supervises a host processor through a single trigger line that the host toggles. Once the block is enabled, the host has a generous opening window in which to make its first toggle. After that, each further toggle must fall inside a narrow band of elapsed time measured from the toggle before it. If a toggle comes too soon, too late or not at all, the block raises a reset pulse at once. The width of that pulse comes from a 2-bit select, and a sticky fault flag is set.

Every accepted toggle clears a count of failures. If failures keep coming without a good toggle in between, the block stops issuing reset pulses at the configured failure limit. It then drives an active-low power-off request and stays halted until the mode controller clears it. All times are counted in periods of an external tick, nominally 1 ms. Every window and width is a parameter in ticks, so a shortened time base needs only different parameter values. The mode controller supplies the enable and a clear strobe, which it pulses on entry to run or standby.

Top module: `wdw_supervisor`

## Requirements
- R1: A level change of `trig_i` in either direction (low to high or high to low) counts as one trigger. It is seen three clock cycles after the change.
- R2: After enable rises, or after a reset pulse falls, a trigger that arrives while the tick count since that point is at most FIRST_WIN_TICKS (default 500) is accepted. The tick that would take the count past that value, with no trigger, is a failure.
- R3: A trigger after the first one that arrives while fewer than MIN_GAP_TICKS (default 200) ticks have passed since the previous accepted trigger is a failure.
- R4: A later trigger is accepted at MIN_GAP_TICKS to MAX_GAP_TICKS (default 300) ticks. The tick that would pass MAX_GAP_TICKS with no trigger is a failure.
- R5: A failure sets `wd_fault_o`, which stays high until `clear_i`. Unless the failure is the final one, `rst_pulse_o` goes high on the clock edge that handles the failure.
- R6: The pulse lasts a number of ticks chosen by `width_sel_i`, latched when the pulse starts: 0 gives 20, 1 gives 10, 2 gives 5, 3 gives 1. A failure detected on a tick gives a pulse of exactly that many tick periods, and the first-trigger window restarts when the pulse falls.
- R7: Each accepted trigger resets the consecutive failure count to zero.
- R8: The FAIL_LIMIT-th consecutive failure (default 5th) gives no pulse. It drives `off_req_n_o` low, and the block then ignores triggers and ticks until `clear_i`.
- R9: While `enable_i` is low there is no supervision: a running pulse is cut off on the next edge and no failure occurs. A new first-trigger window starts when enable rises.
- R10: `clear_i` zeroes the failure count, clears `wd_fault_o` and releases `off_req_n_o` to high.
- R11: Trigger changes made while a reset pulse is high are discarded.
- R12: After reset, `rst_pulse_o` is low, `off_req_n_o` is high and `wd_fault_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle time-base strobe, nominally every 1 ms |
| trig_i | input | 1 | Asynchronous trigger line toggled by the host |
| enable_i | input | 1 | Supervision enable from the mode controller |
| clear_i | input | 1 | Clears failure count, fault flag and power-off request |
| width_sel_i | input | 2 | Reset pulse width select |
| rst_pulse_o | output | 1 | Reset pulse to the host, active high |
| off_req_n_o | output | 1 | Power-off request, active low |
| wd_fault_o | output | 1 | Sticky watchdog failure flag |

## Verification
The bench uses a small configuration: a 50-tick opening window, a 20 to 30 tick band, and pulse widths of 8, 4, 2 and 1 ticks. It sweeps every trigger delay across both windows, one tick at a time, from well inside to past the edge. A window compare that is off by one, or a late-miss check that uses the wrong bound, shows up as a missing or extra pulse at exactly one delay. It measures each pulse width in cycles, so a swapped select decode or a pulse that counts its own starting tick gives the wrong length. It counts pulses up to shutdown with and without a good trigger in between, which catches a counter that never clears, halts one failure early, or still emits a fifth pulse. It also checks that toggles made during a pulse or while disabled leave no trace afterwards.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

  typedef enum logic [2:0] {
    WS_IDLE   = 3'd0,
    WS_PULSE  = 3'd1,
    WS_FIRST  = 3'd2,
    WS_STEADY = 3'd3,
    WS_HALT   = 3'd4
  } wdw_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wdw_edge_sync.sv
module wdw_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q, last_d;

  // shift chain for the asynchronous line
  generate
    if (STAGES == 1) begin : g_single
      assign sync_d = trig_i;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], trig_i};
    end
  endgenerate

  assign last_d = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  // either direction of change is one trigger (R1)
  assign edge_o = sync_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/wdw_window_timer.sv
module wdw_window_timer #(
  parameter int unsigned FIRST_TICKS = 500,
  parameter int unsigned MIN_TICKS   = 200,
  parameter int unsigned MAX_TICKS   = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  input  logic first_i,
  input  logic tick_i,
  output logic expire_o,
  output logic too_soon_o
);
  localparam int unsigned TOP = wdw_pkg::max2(FIRST_TICKS, MAX_TICKS);
  localparam int unsigned CW  = $clog2(TOP + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] limit;
  logic          cnt_en;

  assign limit      = first_i ? CW'(FIRST_TICKS) : CW'(MAX_TICKS);
  assign expire_o   = run_i && tick_i && (cnt_q >= limit);
  assign too_soon_o = !first_i && (cnt_q < CW'(MIN_TICKS));
  assign cnt_en     = run_i && tick_i && (cnt_q < limit);

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R2 / R4: elapsed count never passes the window bound while watching
  a_r2_count_within_window: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= limit));

  // R4: a restart always brings the count back to zero
  a_r4_restart_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0));

endmodule

// File: rtl/wdw_pulse_gen.sv
module wdw_pulse_gen #(
  parameter int unsigned W_SEL0 = 20,
  parameter int unsigned W_SEL1 = 10,
  parameter int unsigned W_SEL2 = 5,
  parameter int unsigned W_SEL3 = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       abort_i,
  input  logic [1:0] sel_i,
  input  logic       tick_i,
  output logic       pulse_o,
  output logic       done_o
);
  localparam int unsigned WMAX = wdw_pkg::max2(wdw_pkg::max2(W_SEL0, W_SEL1),
                                               wdw_pkg::max2(W_SEL2, W_SEL3));
  localparam int unsigned PW   = $clog2(WMAX + 1);

  logic          busy_q, busy_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] len_q, len_d;
  logic [PW-1:0] sel_len;

  always_comb begin
    unique case (sel_i)
      2'd0:    sel_len = PW'(W_SEL0);
      2'd1:    sel_len = PW'(W_SEL1);
      2'd2:    sel_len = PW'(W_SEL2);
      default: sel_len = PW'(W_SEL3);
    endcase
  end

  assign done_o = busy_q && tick_i && ((cnt_q + PW'(1)) == len_q);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    len_d  = len_q;
    if (abort_i) begin
      busy_d = 1'b0;
    end else if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      len_d  = sel_len;
    end else if (busy_q && tick_i) begin
      if (done_o) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
    end
  end

  assign pulse_o = busy_q;

  // R6: the tick count inside a pulse stays below its latched length
  a_r6_count_below_len: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < len_q));

  // R6: the pulse drops on the edge after its last tick
  a_r6_ends_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i && !abort_i) |=> !pulse_o);

endmodule

// File: rtl/wdw_fail_counter.sv
module wdw_fail_counter #(
  parameter int unsigned LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic fail_i,
  output logic final_o
);
  localparam int unsigned CW = $clog2(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;

  assign final_o = (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (fail_i && !final_o) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R8: the count never runs past the give-up point
  a_r8_count_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(LIMIT));

  // R7 / R10: a clear request empties the count
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/wdw_supervisor.sv
module wdw_supervisor #(
  parameter int unsigned FIRST_WIN_TICKS = 500,
  parameter int unsigned MIN_GAP_TICKS   = 200,
  parameter int unsigned MAX_GAP_TICKS   = 300,
  parameter int unsigned PW_SEL0_TICKS   = 20,
  parameter int unsigned PW_SEL1_TICKS   = 10,
  parameter int unsigned PW_SEL2_TICKS   = 5,
  parameter int unsigned PW_SEL3_TICKS   = 1,
  parameter int unsigned FAIL_LIMIT      = 5,
  parameter int unsigned SYNC_STAGES     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       trig_i,
  input  logic       enable_i,
  input  logic       clear_i,
  input  logic [1:0] width_sel_i,
  output logic       rst_pulse_o,
  output logic       off_req_n_o,
  output logic       wd_fault_o
);
  import wdw_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rsync_q[1];

  wdw_state_e state_q, state_d;
  logic       fault_q, fault_d;
  logic       off_n_q, off_n_d;

  logic trig_edge;
  logic expire, too_soon;
  logic watching, early, good, fail;
  logic restart, pulse_start, pulse_done, pulse_on;
  logic last_fail;

  wdw_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) u_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .trig_i (trig_i),
    .edge_o (trig_edge)
  );

  wdw_window_timer #(
    .FIRST_TICKS (FIRST_WIN_TICKS),
    .MIN_TICKS   (MIN_GAP_TICKS),
    .MAX_TICKS   (MAX_GAP_TICKS)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .restart_i  (restart),
    .run_i      (watching),
    .first_i    (state_q == WS_FIRST),
    .tick_i     (tick_i),
    .expire_o   (expire),
    .too_soon_o (too_soon)
  );

  wdw_pulse_gen #(
    .W_SEL0 (PW_SEL0_TICKS),
    .W_SEL1 (PW_SEL1_TICKS),
    .W_SEL2 (PW_SEL2_TICKS),
    .W_SEL3 (PW_SEL3_TICKS)
  ) u_pulse (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (pulse_start),
    .abort_i (!enable_i),
    .sel_i   (width_sel_i),
    .tick_i  (tick_i),
    .pulse_o (pulse_on),
    .done_o  (pulse_done)
  );

  wdw_fail_counter #(
    .LIMIT (FAIL_LIMIT)
  ) u_fails (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr_i   (clear_i || good),
    .fail_i  (fail),
    .final_o (last_fail)
  );

  // classification of the current cycle
  assign watching    = enable_i && ((state_q == WS_FIRST) || (state_q == WS_STEADY));
  assign early       = (state_q == WS_STEADY) && trig_edge && too_soon;
  assign good        = watching && trig_edge && !early;
  assign fail        = watching && !clear_i && (early || (expire && !trig_edge));
  assign pulse_start = fail && !last_fail;
  assign restart     = ((state_q == WS_IDLE) && enable_i) || good ||
                       ((state_q == WS_PULSE) && pulse_done);

  always_comb begin
    state_d = state_q;
    if (!enable_i && (state_q != WS_HALT)) begin
      state_d = WS_IDLE;
    end else begin
      unique case (state_q)
        WS_IDLE:  state_d = WS_FIRST;
        WS_FIRST, WS_STEADY: begin
          if (fail) begin
            state_d = last_fail ? WS_HALT : WS_PULSE;
          end else if (good) begin
            state_d = WS_STEADY;
          end
        end
        WS_PULSE: if (pulse_done) state_d = WS_FIRST;
        WS_HALT:  if (clear_i) state_d = WS_IDLE;
        default:  state_d = WS_IDLE;
      endcase
    end
  end

  always_comb begin
    fault_d = fault_q;
    off_n_d = off_n_q;
    if (clear_i) begin
      fault_d = 1'b0;
      off_n_d = 1'b1;
    end else if (fail) begin
      fault_d = 1'b1;
      if (last_fail) begin
        off_n_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= WS_IDLE;
      fault_q <= 1'b0;
      off_n_q <= 1'b1;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
      off_n_q <= off_n_d;
    end
  end

  assign rst_pulse_o = pulse_on;
  assign off_req_n_o = off_n_q;
  assign wd_fault_o  = fault_q;

  // R8: a power-off request never coexists with a reset pulse
  a_r8_no_pulse_when_off: assert property (@(posedge clk) disable iff (!rst_int_n)
    !off_req_n_o |-> !rst_pulse_o);

  // R8: once given up, stay given up until cleared
  a_r8_halt_holds: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!off_req_n_o && !clear_i) |=> !off_req_n_o);

  // R5: every failure leaves the fault flag raised
  a_r5_fault_after_fail: assert property (@(posedge clk) disable iff (!rst_int_n)
    fail |=> wd_fault_o);

  // R9: dropping enable cuts the pulse
  a_r9_disable_ends_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    !enable_i |=> !rst_pulse_o);

  // R10: clear releases the power-off request and the fault flag
  a_r10_clear_releases: assert property (@(posedge clk) disable iff (!rst_int_n)
    clear_i |=> (off_req_n_o && !wd_fault_o));

endmodule

// File: tb/wdw_supervisor_test.sv
module wdw_supervisor_test;
  localparam int DIV = 8;
  localparam int FW  = 50;
  localparam int MN  = 20;
  localparam int MX  = 30;
  localparam int LIM = 5;
  localparam int W0 = 8, W1 = 4, W2 = 2, W3 = 1;

  logic       clk = 1'b0;
  logic       rst_n, tick, trig, enable, clear;
  logic [1:0] sel;
  logic       rst_pulse, off_n, fault;

  int n_chk = 0;
  int n_fail = 0;
  int tdiv = 0;
  int rises = 0;
  int cur_len = 0;
  int last_len = 0;
  logic prev_pulse = 1'b0;

  always #10 clk = ~clk;

  wdw_supervisor #(
    .FIRST_WIN_TICKS (FW),
    .MIN_GAP_TICKS   (MN),
    .MAX_GAP_TICKS   (MX),
    .PW_SEL0_TICKS   (W0),
    .PW_SEL1_TICKS   (W1),
    .PW_SEL2_TICKS   (W2),
    .PW_SEL3_TICKS   (W3),
    .FAIL_LIMIT      (LIM),
    .SYNC_STAGES     (2)
  ) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .trig_i      (trig),
    .enable_i    (enable),
    .clear_i     (clear),
    .width_sel_i (sel),
    .rst_pulse_o (rst_pulse),
    .off_req_n_o (off_n),
    .wd_fault_o  (fault)
  );

  // tick strobe every DIV cycles, driven away from the active edge
  always @(negedge clk) begin
    if (tdiv == DIV - 1) begin
      tdiv = 0;
      tick = 1'b1;
    end else begin
      tdiv = tdiv + 1;
      tick = 1'b0;
    end
  end

  // pulse monitor: counts rises and measures width in cycles
  always @(negedge clk) begin
    if (rst_pulse === 1'b1) begin
      if (!prev_pulse) begin
        rises   = rises + 1;
        cur_len = 0;
      end
      cur_len = cur_len + 1;
    end else if (prev_pulse) begin
      last_len = cur_len;
    end
    prev_pulse = (rst_pulse === 1'b1);
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    @(posedge clk);
    while (tick !== 1'b1) @(posedge clk);
    @(negedge clk);
    #2;
  endtask

  task automatic fresh();
    enable = 1'b0;
    clear  = 1'b1;
    wait_tick();
    clear  = 1'b0;
    wait_tick();
    enable = 1'b1;
  endtask

  function automatic int width_of(input int s);
    case (s)
      0: return W0;
      1: return W1;
      2: return W2;
      default: return W3;
    endcase
  endfunction

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int r0;
    int g;
    rst_n = 1'b0; tick = 1'b0; trig = 1'b0; enable = 1'b0; clear = 1'b0; sel = 2'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    chk("R12 pulse after reset", rst_pulse, 0);
    chk("R12 off request after reset", off_n, 1);
    chk("R12 fault after reset", fault, 0);

    // R2: opening window swept across every delay
    for (int d = 1; d <= FW + 2; d++) begin
      sel = 2'd0;
      fresh();
      r0 = rises;
      repeat (d) wait_tick();
      trig = ~trig;
      repeat (3) wait_tick();
      chk($sformatf("R2 first trigger at %0d pulses", d), rises - r0, (d > FW) ? 1 : 0);
      chk($sformatf("R2 first trigger at %0d fault", d), fault, (d > FW) ? 1 : 0);
    end

    // R3 / R4: later-trigger band swept across every delay
    for (int d = 1; d <= MX + 2; d++) begin
      sel = 2'd0;
      fresh();
      r0 = rises;
      wait_tick();
      trig = ~trig;
      repeat (d) wait_tick();
      trig = ~trig;
      repeat (3) wait_tick();
      if (d < MN)
        chk($sformatf("R3 early trigger at %0d", d), rises - r0, 1);
      else if (d > MX)
        chk($sformatf("R4 late trigger at %0d", d), rises - r0, 1);
      else
        chk($sformatf("R4 in-band trigger at %0d", d), rises - r0, 0);
    end

    // R1: alternating directions all accepted inside the band
    fresh();
    r0 = rises;
    wait_tick();
    trig = ~trig;
    for (int k = 0; k < 4; k++) begin
      repeat ((MN + MX) / 2) wait_tick();
      trig = ~trig;
    end
    repeat (3) wait_tick();
    chk("R1 both directions accepted", rises - r0, 0);
    chk("R1 no fault", fault, 0);

    // R5 / R6: pulse widths for every select value
    for (int s = 0; s < 4; s++) begin
      sel = s[1:0];
      fresh();
      r0 = rises;
      g = 0;
      while ((rises - r0) < 1 && g < FW + 10) begin wait_tick(); g++; end
      chk($sformatf("R5 pulse issued sel %0d", s), rises - r0, 1);
      chk($sformatf("R5 fault set sel %0d", s), fault, 1);
      g = 0;
      while (rst_pulse && g < 40) begin wait_tick(); g++; end
      chk($sformatf("R6 width cycles sel %0d", s), last_len, width_of(s) * DIV);
    end

    // R11: toggle during the pulse is discarded
    sel = 2'd0;
    fresh();
    r0 = rises;
    g = 0;
    while ((rises - r0) < 1 && g < FW + 10) begin wait_tick(); g++; end
    repeat (2) wait_tick();
    trig = ~trig;
    g = 0;
    while (rst_pulse && g < 40) begin wait_tick(); g++; end
    repeat (5) wait_tick();
    trig = ~trig;
    repeat (3) wait_tick();
    chk("R11 toggle in pulse ignored", rises - r0, 1);

    // R9: abort of a running pulse
    sel = 2'd0;
    fresh();
    r0 = rises;
    g = 0;
    while ((rises - r0) < 1 && g < FW + 10) begin wait_tick(); g++; end
    repeat (2) wait_tick();
    enable = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk("R9 pulse cut by disable", rst_pulse, 0);

    // R9: nothing happens while disabled; enable starts the opening window
    clear = 1'b1;
    wait_tick();
    clear = 1'b0;
    r0 = rises;
    for (int k = 0; k < 2 * FW; k++) begin
      wait_tick();
      if (k % 7 == 3) trig = ~trig;
    end
    chk("R9 no pulse while disabled", rises - r0, 0);
    chk("R9 no fault while disabled", fault, 0);
    enable = 1'b1;
    repeat (FW + 3) wait_tick();
    chk("R9 window after enable", rises - r0, 1);

    // R8: give up on the final failure
    sel = 2'd3;
    fresh();
    r0 = rises;
    g = 0;
    while (off_n && g < LIM * (FW + W0 + 5)) begin wait_tick(); g++; end
    chk("R8 pulses before shutdown", rises - r0, LIM - 1);
    chk("R8 off request low", off_n, 0);
    chk("R5 fault at shutdown", fault, 1);
    for (int k = 0; k < 2 * FW; k++) begin
      wait_tick();
      if (k % 9 == 4) trig = ~trig;
    end
    chk("R8 halted, no pulses", rises - r0, LIM - 1);
    chk("R8 off request held", off_n, 0);
    clear = 1'b1;
    wait_tick();
    clear = 1'b0;
    chk("R10 off request released", off_n, 1);
    chk("R10 fault cleared", fault, 0);

    // R7: a good trigger restarts the failure count
    sel = 2'd3;
    fresh();
    r0 = rises;
    g = 0;
    while ((rises - r0) < LIM - 1 && g < LIM * (FW + 10)) begin wait_tick(); g++; end
    g = 0;
    while (rst_pulse && g < 40) begin wait_tick(); g++; end
    wait_tick();
    trig = ~trig;
    g = 0;
    while (off_n && g < LIM * (MX + FW + 10)) begin wait_tick(); g++; end
    chk("R7 pulses with count restart", rises - r0, 2 * (LIM - 1));
    chk("R7 shutdown reached", off_n, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule